// File: doc/BRIEF.md
# Single-Entry Jump Target Cache

This block sits beside the instruction fetch unit of a core that fetches 16-bit words. It keeps one entry for the most recently taken jump that is allowed to use it. The entry holds the two instruction words found at that jump's destination and a tag equal to the jump's own address. When the same jump is taken again, the block supplies both words at once from the entry and moves the fetch pointer past them. No memory access is then needed for the first two words at the destination.

A taken jump that is allowed to use the cache but finds no matching entry loads a new one. It redirects the fetch pointer to the destination, stores the next two fetch words that are accepted, and only then marks the entry valid. A branch into another code segment or the entry into an interrupt service routine clears the entry. Jumps made while code runs from internal program memory bypass the cache. Cycles stolen by a peripheral data transfer freeze the fetch pointer, so the resume point after a hit stays correct.

Top module: `jump_target_cache`

## Requirements
- R1: While reset is active, and after it, `hit` is 0, both hit words are 0, `fetch_addr` is 0 and the entry is empty, so the first taken jump misses.
- R2: `jmp_class` codes 0 (relative), 1 (absolute) and 2 to 5 (the four bit-test jumps) may load and hit the entry; codes 6 (segment branch) and 7 (other) never load, never hit and leave the entry unchanged.
- R3: A taken jump that is allowed to use the cache and does not hit sets `fetch_addr` to `jmp_target` one cycle later. The next two accepted fetch words become the cached words in order (destination, destination+2), and the entry is tagged with `jmp_pc`.
- R4: A taken, cacheable jump whose `jmp_pc` equals the tag of a valid entry raises `hit` for the following cycle. In that cycle `hit_word0`/`hit_word1` show the cached words and `fetch_addr` is `jmp_target`+4, never `jmp_target`+2.
- R5: A taken cacheable jump with a different `jmp_pc` replaces the entry, so the earlier jump then misses.
- R6: `seg_change` or `irq_entry` empties the entry, so the next jump misses.
- R7: Presenting a jump address with `jmp_taken` low neither loads nor clears the entry.
- R8: While `pec_cycle` is high, `fetch_addr` holds and `fetch_word` is not stored, including right after a hit.
- R9: With `internal_mem` high, a taken jump gives no hit and loads nothing; the existing entry survives and still hits later.
- R10: An accepted fetch (`fetch_valid` high, `pec_cycle` low, no taken jump) advances `fetch_addr` by 2.
- R11: A taken jump during a fill abandons the partial fill; a cacheable miss restarts the fill under the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| jmp_taken | input | 1 | A jump is taken this cycle |
| jmp_pc | input | AW | Address of the jump instruction itself |
| jmp_target | input | AW | Destination address of the jump |
| jmp_class | input | 3 | Jump class code (see R2) |
| internal_mem | input | 1 | Code is executing from internal program memory |
| fetch_valid | input | 1 | A word fetched from `fetch_addr` is returned |
| fetch_word | input | DW | The returned word |
| pec_cycle | input | 1 | A peripheral data-transfer cycle occupies the bus |
| seg_change | input | 1 | A branch to another code segment is taken |
| irq_entry | input | 1 | An interrupt service routine is entered |
| hit | output | 1 | The previous cycle's jump hit the entry |
| hit_word0 | output | DW | Cached word at the destination (0 when no hit) |
| hit_word1 | output | DW | Cached word at destination+2 (0 when no hit) |
| fetch_addr | output | AW | Address of the next word to fetch |

## Verification
The assertions assume that a jump is signalled by a single `jmp_taken` cycle. They also assume that fetch returns arriving in the same cycle as a taken jump are discarded, and that `pec_cycle` marks every cycle whose bus traffic is not an instruction fetch. The stimulus raises each event in a cycle of its own, with no overlap of jump, invalidation and fetch return unless a requirement calls for the overlap. It sends only word-aligned addresses. It also keeps every jump destination far enough from the top of the address space that destination+4 cannot wrap.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

  typedef enum logic [2:0] {
    JC_REL   = 3'd0,
    JC_ABS   = 3'd1,
    JC_BIT_A = 3'd2,
    JC_BIT_B = 3'd3,
    JC_BIT_C = 3'd4,
    JC_BIT_D = 3'd5,
    JC_SEG   = 3'd6,
    JC_OTHER = 3'd7
  } jclass_e;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_W0   = 2'd1,
    FILL_W1   = 2'd2
  } fill_st_e;

  // Relative, absolute and bit-test jumps may use the cache.
  function automatic logic is_cacheable(input logic [2:0] code);
    jclass_e c;
    c = jclass_e'(code);
    return (c != JC_SEG) && (c != JC_OTHER);
  endfunction

endpackage

// File: rtl/jtc_entry.sv
module jtc_entry #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [AW-1:0] start_tag,
  input  logic          wr0,
  input  logic          wr1,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] probe_tag,
  output logic          valid,
  output logic          match,
  output logic [DW-1:0] word0,
  output logic [DW-1:0] word1
);

  logic          valid_q, valid_d;
  logic [AW-1:0] tag_q;
  logic [DW-1:0] w0_q, w1_q;

  // Invalidation beats a new fill, which beats completion of a fill.
  always_comb begin
    valid_d = valid_q;
    if (clr)        valid_d = 1'b0;
    else if (start) valid_d = 1'b0;
    else if (wr1)   valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tag_q <= '0;
    else if (start) tag_q <= start_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   w0_q <= '0;
    else if (wr0) w0_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   w1_q <= '0;
    else if (wr1) w1_q <= wdata;
  end

  assign valid = valid_q;
  assign match = valid_q && (tag_q == probe_tag);
  assign word0 = w0_q;
  assign word1 = w1_q;

endmodule

// File: rtl/jtc_fill_ctrl.sv
module jtc_fill_ctrl
  import jtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic accept,
  output logic wr0,
  output logic wr1
);

  fill_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = FILL_W0;
    end else if (abort) begin
      st_d = FILL_IDLE;
    end else begin
      unique case (st_q)
        FILL_W0:   if (accept) st_d = FILL_W1;
        FILL_W1:   if (accept) st_d = FILL_IDLE;
        default:   st_d = FILL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FILL_IDLE;
    else        st_q <= st_d;
  end

  assign wr0 = (st_q == FILL_W0) && accept && !abort && !start;
  assign wr1 = (st_q == FILL_W1) && accept && !abort && !start;

endmodule

// File: rtl/jtc_fetch_seq.sv
module jtc_fetch_seq #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  input  logic          advance,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign addr_en = redirect || advance;

  always_comb begin
    addr_d = addr_q;
    if (redirect)     addr_d = redirect_addr;
    else if (advance) addr_d = addr_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/jump_target_cache.sv
module jump_target_cache
  import jtc_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          jmp_taken,
  input  logic [AW-1:0] jmp_pc,
  input  logic [AW-1:0] jmp_target,
  input  logic [2:0]    jmp_class,
  input  logic          internal_mem,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_word,
  input  logic          pec_cycle,
  input  logic          seg_change,
  input  logic          irq_entry,
  output logic          hit,
  output logic [DW-1:0] hit_word0,
  output logic [DW-1:0] hit_word1,
  output logic [AW-1:0] fetch_addr
);

  localparam logic [AW-1:0] SKIP = AW'(2 * (DW / 8));

  // Reset: asserted asynchronously, released through a synchronizer.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_sync;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = rst_sync_q[SYNC_STAGES-1];

  logic          inval, usable, lookup_hit, fill_start, fill_abort, accept;
  logic          entry_valid, entry_match, wr0, wr1;
  logic [DW-1:0] ent_w0, ent_w1;
  logic [AW-1:0] redirect_addr;
  logic          hit_q, hit_d;

  assign inval      = seg_change || irq_entry;
  assign usable     = is_cacheable(jmp_class) && !internal_mem && !inval;
  assign lookup_hit = jmp_taken && usable && entry_match;
  assign fill_start = jmp_taken && usable && !entry_match;
  assign fill_abort = inval || (jmp_taken && !fill_start);
  assign accept     = fetch_valid && !pec_cycle && !jmp_taken;

  assign redirect_addr = lookup_hit ? (jmp_target + SKIP) : jmp_target;

  jtc_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clr       (inval),
    .start     (fill_start),
    .start_tag (jmp_pc),
    .wr0       (wr0),
    .wr1       (wr1),
    .wdata     (fetch_word),
    .probe_tag (jmp_pc),
    .valid     (entry_valid),
    .match     (entry_match),
    .word0     (ent_w0),
    .word1     (ent_w1)
  );

  jtc_fill_ctrl u_fill (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .start  (fill_start),
    .abort  (fill_abort),
    .accept (accept),
    .wr0    (wr0),
    .wr1    (wr1)
  );

  jtc_fetch_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .redirect      (jmp_taken),
    .redirect_addr (redirect_addr),
    .advance       (accept),
    .addr          (fetch_addr)
  );

  assign hit_d = lookup_hit;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) hit_q <= 1'b0;
    else             hit_q <= hit_d;
  end

  assign hit       = hit_q;
  assign hit_word0 = hit_q ? ent_w0 : '0;
  assign hit_word1 = hit_q ? ent_w1 : '0;

endmodule

// File: rtl/jump_target_cache_chk.sv
module jump_target_cache_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          jmp_taken,
  input logic [AW-1:0] jmp_target,
  input logic [2:0]    jmp_class,
  input logic          internal_mem,
  input logic          fetch_valid,
  input logic          pec_cycle,
  input logic          seg_change,
  input logic          irq_entry,
  input logic          hit,
  input logic [AW-1:0] fetch_addr,
  input logic          entry_valid
);

  assert_hit_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_taken |=> (!hit || (fetch_addr == ($past(jmp_target) + AW'(4)))));

  assert_hit_after_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(jmp_taken));

  assert_no_hit_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_taken && (jmp_class > 3'd5)) |=> !hit);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_taken && internal_mem) |=> !hit);

  assert_invalidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_change || irq_entry) |=> !entry_valid);

  assert_pec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_cycle && !jmp_taken) |=> $stable(fetch_addr));

  assert_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !pec_cycle && !jmp_taken) |=> (fetch_addr == ($past(fetch_addr) + AW'(2))));

endmodule

bind jump_target_cache jump_target_cache_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .jmp_taken    (jmp_taken),
  .jmp_target   (jmp_target),
  .jmp_class    (jmp_class),
  .internal_mem (internal_mem),
  .fetch_valid  (fetch_valid),
  .pec_cycle    (pec_cycle),
  .seg_change   (seg_change),
  .irq_entry    (irq_entry),
  .hit          (hit),
  .fetch_addr   (fetch_addr),
  .entry_valid  (entry_valid)
);

// File: tb/jump_target_cache_tb.sv
module jump_target_cache_tb;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NV = 31;

  typedef struct packed {
    logic          jt;
    logic [AW-1:0] pc;
    logic [AW-1:0] tgt;
    logic [2:0]    cls;
    logic          im;
    logic          fv;
    logic [DW-1:0] fw;
    logic          pec;
    logic          seg;
    logic          irq;
    logic          e_hit;
    logic [AW-1:0] e_fa;
    logic [DW-1:0] e_w0;
    logic [DW-1:0] e_w1;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b1, 24'h100, 24'h400, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h400, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b0, 24'h402, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h1111, 1'b1, 1'b0, 1'b0, 1'b0, 24'h402, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'hBBBB, 1'b0, 1'b0, 1'b0, 1'b0, 24'h404, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'hCCCC, 1'b0, 1'b0, 1'b0, 1'b0, 24'h406, 16'h0000, 16'h0000},
    '{1'b0, 24'h100, 24'h400, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h406, 16'h0000, 16'h0000},
    '{1'b1, 24'h100, 24'h400, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h404, 16'hAAAA, 16'hBBBB},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h9999, 1'b1, 1'b0, 1'b0, 1'b0, 24'h404, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'hDDDD, 1'b0, 1'b0, 1'b0, 1'b0, 24'h406, 16'h0000, 16'h0000},
    '{1'b1, 24'h100, 24'h400, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h400, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b1, 1'b1, 16'hEEEE, 1'b0, 1'b0, 1'b0, 1'b0, 24'h402, 16'h0000, 16'h0000},
    '{1'b1, 24'h100, 24'h400, 3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h404, 16'hAAAA, 16'hBBBB},
    '{1'b1, 24'h200, 24'h800, 3'd6, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h800, 16'h0000, 16'h0000},
    '{1'b1, 24'h100, 24'h400, 3'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h404, 16'hAAAA, 16'hBBBB},
    '{1'b1, 24'h300, 24'h900, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h900, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 24'h902, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h5678, 1'b0, 1'b0, 1'b0, 1'b0, 24'h904, 16'h0000, 16'h0000},
    '{1'b1, 24'h100, 24'h400, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h400, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h0A0A, 1'b0, 1'b0, 1'b0, 1'b0, 24'h402, 16'h0000, 16'h0000},
    '{1'b1, 24'h300, 24'h900, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h900, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h1357, 1'b0, 1'b0, 1'b0, 1'b0, 24'h902, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h2468, 1'b0, 1'b0, 1'b0, 1'b0, 24'h904, 16'h0000, 16'h0000},
    '{1'b1, 24'h300, 24'h900, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 24'h904, 16'h1357, 16'h2468},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 24'h904, 16'h0000, 16'h0000},
    '{1'b1, 24'h300, 24'h900, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h900, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h4444, 1'b0, 1'b0, 1'b0, 1'b0, 24'h902, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 24'h904, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 24'h904, 16'h0000, 16'h0000},
    '{1'b1, 24'h300, 24'h900, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h900, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b0, 24'h902, 16'h0000, 16'h0000},
    '{1'b0, 24'h000, 24'h000, 3'd0, 1'b0, 1'b1, 16'h8888, 1'b0, 1'b0, 1'b0, 1'b0, 24'h904, 16'h0000, 16'h0000}
  };

  logic          clk;
  logic          rst_n;
  logic          jmp_taken;
  logic [AW-1:0] jmp_pc;
  logic [AW-1:0] jmp_target;
  logic [2:0]    jmp_class;
  logic          internal_mem;
  logic          fetch_valid;
  logic [DW-1:0] fetch_word;
  logic          pec_cycle;
  logic          seg_change;
  logic          irq_entry;
  logic          hit;
  logic [DW-1:0] hit_word0;
  logic [DW-1:0] hit_word1;
  logic [AW-1:0] fetch_addr;

  int n_checks;
  int n_fail;
  bit finished;

  jump_target_cache #(.AW(AW), .DW(DW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .jmp_taken    (jmp_taken),
    .jmp_pc       (jmp_pc),
    .jmp_target   (jmp_target),
    .jmp_class    (jmp_class),
    .internal_mem (internal_mem),
    .fetch_valid  (fetch_valid),
    .fetch_word   (fetch_word),
    .pec_cycle    (pec_cycle),
    .seg_change   (seg_change),
    .irq_entry    (irq_entry),
    .hit          (hit),
    .hit_word0    (hit_word0),
    .hit_word1    (hit_word1),
    .fetch_addr   (fetch_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_of(input int i);
    case (i)
      0, 3, 15, 16, 18, 25, 26, 29, 30: return "R3";
      1, 4, 8:                          return "R10";
      2, 7:                             return "R8";
      5:                                return "R7";
      6:                                return "R4";
      9, 10, 11:                        return "R9";
      12, 13:                           return "R2";
      14, 17:                           return "R5";
      19, 20, 21, 22:                   return "R11";
      default:                          return "R6";
    endcase
  endfunction

  task automatic check_out(input string req, input logic e_hit, input logic [AW-1:0] e_fa,
                           input logic [DW-1:0] e_w0, input logic [DW-1:0] e_w1);
    n_checks++;
    if (hit !== e_hit || fetch_addr !== e_fa || hit_word0 !== e_w0 || hit_word1 !== e_w1) begin
      n_fail++;
      $display("FAIL %s: hit=%0b fa=%h w0=%h w1=%h, expected hit=%0b fa=%h w0=%h w1=%h",
               req, hit, fetch_addr, hit_word0, hit_word1, e_hit, e_fa, e_w0, e_w1);
    end
  endtask

  task automatic idle_inputs();
    jmp_taken = 1'b0; jmp_pc = '0; jmp_target = '0; jmp_class = 3'd0;
    internal_mem = 1'b0; fetch_valid = 1'b0; fetch_word = '0;
    pec_cycle = 1'b0; seg_change = 1'b0; irq_entry = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    jmp_taken = v.jt; jmp_pc = v.pc; jmp_target = v.tgt; jmp_class = v.cls;
    internal_mem = v.im; fetch_valid = v.fv; fetch_word = v.fw;
    pec_cycle = v.pec; seg_change = v.seg; irq_entry = v.irq;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check_out("R1", 1'b0, '0, '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1", 1'b0, '0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      check_out(req_of(i), TBL[i].e_hit, TBL[i].e_fa, TBL[i].e_w0, TBL[i].e_w1);
    end

    // R1: reset in mid-run empties a valid entry and clears outputs.
    idle_inputs();
    rst_n = 1'b0;
    #2;
    check_out("R1", 1'b0, '0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    jmp_taken = 1'b1; jmp_pc = 24'h300; jmp_target = 24'h900; jmp_class = 3'd5;
    @(negedge clk);
    check_out("R1", 1'b0, 24'h900, '0, '0);
    idle_inputs();
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule